// File: doc/BRIEF.md
# I2C Byte Buffer Stretch Controller

This block sits between a byte-level I2C bit engine and the register or DMA side of an I2C controller. It keeps one transmit holding byte and one receive holding byte. It reports their state through three flags: transmit empty, receive not empty, and byte-transfer complete. When the engine has finished a byte and the matching buffer is not ready, the block holds the clock line low through a registered stretch output. That means an empty buffer for transmit, or an unread buffer for receive.

A slave can turn stretching off. In that case a late service is not absorbed by stretching. It is detected instead: an incoming byte that meets an unread buffer is dropped and raises overrun, and a transmit load from an empty buffer sends all ones and raises underrun. The block drives DMA requests from the buffer flags and takes a one-cycle acknowledge for each transfer. It records the DMA end-of-transfer pulse as a sticky status. It also decides the ACK bit for each received byte. A cleared acknowledge enable, or the last-transfer mode once the DMA side has finished, makes a master receiver answer with NACK.

Top module: `i2c_bytebuf_stretch`

## Requirements
- R1: After reset, tx_empty is 1, and rx_full, xfer_cmpl, scl_hold, overrun, underrun, dma_done, dma_tx_req and dma_rx_req are all 0.
- R2: In transmit direction (cfg_rx=0) with stretching in effect, an eng_byte_done while tx_empty is 1 sets xfer_cmpl on the next edge and scl_hold one edge later. A buffer write clears tx_empty and xfer_cmpl on its edge, and scl_hold falls one edge after that.
- R3: In receive direction (cfg_rx=1) with stretching in effect, an eng_byte_done while rx_full is 1 parks the new byte and sets xfer_cmpl, and scl_hold rises one edge later. A read then presents the parked byte on rd_data, keeps rx_full at 1 and clears xfer_cmpl. scl_hold falls one edge after that.
- R4: With stretching disabled, an eng_byte_done in receive direction while rx_full is 1 sets overrun, drops the new byte (rd_data keeps the unread byte), and sets neither xfer_cmpl nor scl_hold.
- R5: With stretching disabled, an eng_load while tx_empty is 1 presents all ones (8'hFF at the default width) on eng_tx_data and sets underrun.
- R6: Stretching is disabled only when cfg_slave=1 and cfg_no_stretch=1; a master ignores cfg_no_stretch and still stretches.
- R7: dma_tx_req equals cfg_dma_en and transmit direction and tx_empty. A dma_tx_ack writes dma_wdata into the transmit buffer, and the request drops on that edge.
- R8: dma_rx_req equals cfg_dma_en and receive direction and rx_full. rd_data carries the byte while the request is high, and a dma_rx_ack with no parked byte clears rx_full and the request.
- R9: eng_ack is 0 whenever cfg_ack_en is 0.
- R10: eng_ack is 0 when cfg_last_xfer=1, cfg_slave=0, cfg_rx=1 and dma_done=1. With cfg_ack_en=1 it is 1 in every other case.
- R11: A dma_eot pulse sets dma_done, which stays set until flag_clr; flag_clr clears dma_done, overrun and underrun on its edge.
- R12: An eng_load while tx_empty is 0 hands the buffered byte to eng_tx_data and sets tx_empty on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx | input | 1 | Direction: 1 receive, 0 transmit |
| cfg_slave | input | 1 | 1 when the controller acts as slave |
| cfg_no_stretch | input | 1 | Request to disable clock stretching (slave only) |
| cfg_dma_en | input | 1 | Enable DMA requests |
| cfg_ack_en | input | 1 | Acknowledge enable for received bytes |
| cfg_last_xfer | input | 1 | NACK the byte after DMA end of transfer (master receive) |
| wr_vld | input | 1 | Register write of the transmit buffer |
| wr_data | input | DATA_W | Register write data |
| rd_vld | input | 1 | Register read of the receive buffer |
| rd_data | output | DATA_W | Receive buffer contents |
| dma_tx_ack | input | 1 | DMA write acknowledge, one cycle |
| dma_wdata | input | DATA_W | DMA write data |
| dma_rx_ack | input | 1 | DMA read acknowledge, one cycle |
| dma_eot | input | 1 | DMA end-of-transfer pulse |
| flag_clr | input | 1 | Clears overrun, underrun and dma_done |
| eng_load | input | 1 | Engine takes the next transmit byte |
| eng_byte_done | input | 1 | Engine finished a byte |
| eng_rx_data | input | DATA_W | Byte received by the engine |
| eng_tx_data | output | DATA_W | Byte offered to the engine |
| eng_ack | output | 1 | ACK (1) or NACK (0) for the current received byte |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| xfer_cmpl | output | 1 | Byte finished while the buffer was not ready |
| overrun | output | 1 | Sticky receive overrun |
| underrun | output | 1 | Sticky transmit underrun |
| dma_done | output | 1 | Sticky DMA end of transfer |
| scl_hold | output | 1 | Hold SCL low (registered) |
| dma_tx_req | output | 1 | DMA write request |
| dma_rx_req | output | 1 | DMA read request |

## Verification
A wrong stretch decision shows at scl_hold two edges after the engine's byte_done. It can appear as a hold that never rises, or as one that stays high after the buffer write or read that should release it. A lost parked byte shows on rd_data in the cycle after the first read, as the first byte repeated or a missing value. A wrong overrun or underrun decision shows on the sticky flag one edge after the offending engine pulse, together with a stretch that should not happen. A stale DMA request or done flag shows on the edge after the acknowledge, or in a wrong eng_ack, which the engine samples at the next byte boundary.

// File: rtl/i2c_bb_pkg.sv
package i2c_bb_pkg;
  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } dir_e;
endpackage

// File: rtl/i2c_bb_txpath.sv
module i2c_bb_txpath #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              stretch_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              load,
  input  logic              byte_done,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tbe,
  output logic              btc,
  output logic              udr
);
  localparam logic [DATA_W-1:0] FILL = {DATA_W{1'b1}};

  logic [DATA_W-1:0] buf_q, buf_d;
  logic              tbe_q, tbe_d;
  logic              btc_q, btc_d;
  logic              udr_q, udr_d;

  always_comb begin
    buf_d = buf_q;
    tbe_d = tbe_q;
    btc_d = btc_q & tx_mode;
    udr_d = udr_q & ~flag_clr;
    if (load) begin
      if (tbe_q) begin
        if (!stretch_en) udr_d = 1'b1;
      end else begin
        tbe_d = 1'b1;
      end
    end
    if (byte_done && tx_mode && tbe_q && stretch_en && !wr_en) btc_d = 1'b1;
    if (wr_en) begin
      buf_d = wr_byte;
      tbe_d = 1'b0;
      btc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      tbe_q <= 1'b1;
      btc_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      tbe_q <= tbe_d;
      btc_q <= btc_d;
      udr_q <= udr_d;
    end
  end

  assign tx_byte = tbe_q ? FILL : buf_q;
  assign tbe     = tbe_q;
  assign btc     = btc_q;
  assign udr     = udr_q;

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tbe_q); // R2
  AST_UDR_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_q && !$past(udr_q)) |-> $past(tbe_q && !stretch_en)); // R5
endmodule

// File: rtl/i2c_bb_rxpath.sv
module i2c_bb_rxpath #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_mode,
  input  logic              stretch_en,
  input  logic              rd_en,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rbne,
  output logic              btc,
  output logic              ovr
);
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [DATA_W-1:0] park_q, park_d;
  logic              rbne_q, rbne_d;
  logic              btc_q, btc_d;
  logic              ovr_q, ovr_d;
  logic              room;

  assign room = !rbne_q || (rd_en && !btc_q);

  always_comb begin
    buf_d  = buf_q;
    park_d = park_q;
    rbne_d = rbne_q;
    btc_d  = btc_q & rx_mode;
    ovr_d  = ovr_q & ~flag_clr;
    if (rd_en && rbne_q) begin
      if (btc_q) begin
        buf_d = park_q;
        btc_d = 1'b0;
      end else begin
        rbne_d = 1'b0;
      end
    end
    if (byte_done && rx_mode) begin
      if (room) begin
        buf_d  = rx_byte;
        rbne_d = 1'b1;
      end else if (stretch_en) begin
        park_d = rx_byte;
        btc_d  = 1'b1;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      park_q <= '0;
      rbne_q <= 1'b0;
      btc_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      park_q <= park_d;
      rbne_q <= rbne_d;
      btc_q  <= btc_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rd_byte = buf_q;
  assign rbne    = rbne_q;
  assign btc     = btc_q;
  assign ovr     = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !$past(ovr_q)) |-> $past(rbne_q && !stretch_en)); // R4
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rbne_q && !btc_q && !byte_done) |=> !rbne_q); // R8
endmodule

// File: rtl/i2c_bb_ctrl.sv
module i2c_bb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic btc_tx,
  input  logic btc_rx,
  input  logic dma_eot,
  input  logic flag_clr,
  input  logic ack_en,
  input  logic last_xfer,
  input  logic master_rx,
  output logic hold,
  output logic done,
  output logic ack
);
  logic hold_q, hold_d;
  logic done_q, done_d;

  always_comb begin
    hold_d = btc_tx | btc_rx;
    done_d = done_q;
    if (flag_clr) done_d = 1'b0;
    if (dma_eot)  done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      done_q <= done_d;
    end
  end

  assign hold = hold_q;
  assign done = done_q;
  assign ack  = ack_en && !(last_xfer && master_rx && done_q);

  AST_HOLD_AFTER_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (btc_tx || btc_rx) |=> hold_q); // R2
  AST_EOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_eot) |=> done_q); // R11
endmodule

// File: rtl/i2c_bytebuf_stretch.sv
module i2c_bytebuf_stretch
  import i2c_bb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx,
  input  logic              cfg_slave,
  input  logic              cfg_no_stretch,
  input  logic              cfg_dma_en,
  input  logic              cfg_ack_en,
  input  logic              cfg_last_xfer,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dma_tx_ack,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              dma_rx_ack,
  input  logic              dma_eot,
  input  logic              flag_clr,
  input  logic              eng_load,
  input  logic              eng_byte_done,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic [DATA_W-1:0] eng_tx_data,
  output logic              eng_ack,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              xfer_cmpl,
  output logic              overrun,
  output logic              underrun,
  output logic              dma_done,
  output logic              scl_hold,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  dir_e              dir;
  logic              tx_mode, rx_mode, stretch_en;
  logic              wr_en, rd_en;
  logic [DATA_W-1:0] wr_byte;
  logic              btc_tx, btc_rx;

  assign dir        = cfg_rx ? DIR_RX : DIR_TX;
  assign tx_mode    = (dir == DIR_TX);
  assign rx_mode    = (dir == DIR_RX);
  assign stretch_en = !(cfg_slave && cfg_no_stretch);
  assign wr_en      = wr_vld | dma_tx_ack;
  assign wr_byte    = dma_tx_ack ? dma_wdata : wr_data;
  assign rd_en      = rd_vld | dma_rx_ack;

  i2c_bb_txpath #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_mode   (tx_mode),
    .stretch_en(stretch_en),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .load      (eng_load),
    .byte_done (eng_byte_done),
    .flag_clr  (flag_clr),
    .tx_byte   (eng_tx_data),
    .tbe       (tx_empty),
    .btc       (btc_tx),
    .udr       (underrun)
  );

  i2c_bb_rxpath #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_mode   (rx_mode),
    .stretch_en(stretch_en),
    .rd_en     (rd_en),
    .byte_done (eng_byte_done),
    .rx_byte   (eng_rx_data),
    .flag_clr  (flag_clr),
    .rd_byte   (rd_data),
    .rbne      (rx_full),
    .btc       (btc_rx),
    .ovr       (overrun)
  );

  i2c_bb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .btc_tx   (btc_tx),
    .btc_rx   (btc_rx),
    .dma_eot  (dma_eot),
    .flag_clr (flag_clr),
    .ack_en   (cfg_ack_en),
    .last_xfer(cfg_last_xfer),
    .master_rx(rx_mode && !cfg_slave),
    .hold     (scl_hold),
    .done     (dma_done),
    .ack      (eng_ack)
  );

  assign xfer_cmpl  = btc_tx | btc_rx;
  assign dma_tx_req = cfg_dma_en && tx_mode && tx_empty;
  assign dma_rx_req = cfg_dma_en && rx_mode && rx_full;

  AST_TX_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_req && dma_tx_ack) |=> !dma_tx_req); // R7
  AST_RX_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_req && dma_rx_ack && !btc_rx && !eng_byte_done) |=> !dma_rx_req); // R8
  AST_LAST_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && cfg_last_xfer && cfg_rx && !cfg_slave) |-> !eng_ack); // R10
  AST_NACK_NO_ACKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ack_en) |-> !eng_ack); // R9
endmodule

// File: tb/i2c_bytebuf_stretch_bench.sv
module i2c_bytebuf_stretch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_rx, cfg_slave, cfg_no_stretch, cfg_dma_en, cfg_ack_en, cfg_last_xfer;
  logic          wr_vld, rd_vld, dma_tx_ack, dma_rx_ack, dma_eot, flag_clr;
  logic          eng_load, eng_byte_done;
  logic [DW-1:0] wr_data, dma_wdata, eng_rx_data, rd_data, eng_tx_data;
  logic          eng_ack, tx_empty, rx_full, xfer_cmpl, overrun, underrun, dma_done;
  logic          scl_hold, dma_tx_req, dma_rx_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bytebuf_stretch #(.DATA_W(DW)) u_i2c_bytebuf_stretch (
    .clk(clk), .rst_n(rst_n),
    .cfg_rx(cfg_rx), .cfg_slave(cfg_slave), .cfg_no_stretch(cfg_no_stretch),
    .cfg_dma_en(cfg_dma_en), .cfg_ack_en(cfg_ack_en), .cfg_last_xfer(cfg_last_xfer),
    .wr_vld(wr_vld), .wr_data(wr_data), .rd_vld(rd_vld), .rd_data(rd_data),
    .dma_tx_ack(dma_tx_ack), .dma_wdata(dma_wdata), .dma_rx_ack(dma_rx_ack),
    .dma_eot(dma_eot), .flag_clr(flag_clr),
    .eng_load(eng_load), .eng_byte_done(eng_byte_done), .eng_rx_data(eng_rx_data),
    .eng_tx_data(eng_tx_data), .eng_ack(eng_ack),
    .tx_empty(tx_empty), .rx_full(rx_full), .xfer_cmpl(xfer_cmpl),
    .overrun(overrun), .underrun(underrun), .dma_done(dma_done),
    .scl_hold(scl_hold), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_vld = 0; rd_vld = 0; dma_tx_ack = 0; dma_rx_ack = 0; dma_eot = 0;
    flag_clr = 0; eng_load = 0; eng_byte_done = 0;
  endtask

  task automatic cpu_write(input logic [DW-1:0] d);
    wr_vld = 1; wr_data = d; step(); wr_vld = 0;
  endtask

  task automatic cpu_read();
    rd_vld = 1; step(); rd_vld = 0;
  endtask

  task automatic eng_rx(input logic [DW-1:0] d);
    eng_byte_done = 1; eng_rx_data = d; step(); eng_byte_done = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_reset();
    check("R1", "tx_empty", tx_empty, 1);
    check("R1", "rx_full", rx_full, 0);
    check("R1", "xfer_cmpl", xfer_cmpl, 0);
    check("R1", "scl_hold", scl_hold, 0);
    check("R1", "sticky flags", {overrun, underrun, dma_done}, 0);
    check("R1", "dma reqs", {dma_tx_req, dma_rx_req}, 0);
  endtask

  task automatic t_tx_stretch();
    cfg_rx = 0; cfg_slave = 0; cfg_no_stretch = 0;
    cpu_write(8'hA5);
    check("R2", "tx_empty after write", tx_empty, 0);
    eng_load = 1; #1;
    check("R12", "byte offered", eng_tx_data, 8'hA5);
    step(); eng_load = 0;
    check("R12", "tx_empty after load", tx_empty, 1);
    eng_byte_done = 1; step(); eng_byte_done = 0;
    check("R2", "xfer_cmpl on empty", xfer_cmpl, 1);
    check("R2", "hold not yet", scl_hold, 0);
    step();
    check("R2", "hold raised", scl_hold, 1);
    cpu_write(8'h3C);
    check("R2", "xfer_cmpl cleared", xfer_cmpl, 0);
    check("R2", "hold lingers one edge", scl_hold, 1);
    step();
    check("R2", "hold released", scl_hold, 0);
    eng_load = 1; step(); eng_load = 0;
  endtask

  task automatic t_rx_stretch();
    cfg_rx = 1; cfg_slave = 0; cfg_no_stretch = 0;
    eng_rx(8'h11);
    check("R3", "rx_full first", rx_full, 1);
    check("R3", "no cmpl first", xfer_cmpl, 0);
    eng_rx(8'h22);
    check("R3", "cmpl on full", xfer_cmpl, 1);
    step();
    check("R3", "hold raised", scl_hold, 1);
    check("R3", "first byte", rd_data, 8'h11);
    cpu_read();
    check("R3", "parked byte", rd_data, 8'h22);
    check("R3", "still full", rx_full, 1);
    check("R3", "cmpl cleared", xfer_cmpl, 0);
    step();
    check("R3", "hold released", scl_hold, 0);
    cpu_read();
    check("R3", "empty after 2nd read", rx_full, 0);
  endtask

  task automatic t_rx_overrun();
    cfg_rx = 1; cfg_slave = 1; cfg_no_stretch = 1;
    eng_rx(8'h55);
    eng_rx(8'h66);
    check("R4", "overrun set", overrun, 1);
    check("R4", "no cmpl", xfer_cmpl, 0);
    check("R4", "byte kept", rd_data, 8'h55);
    step();
    check("R4", "no hold", scl_hold, 0);
    cpu_read();
    check("R4", "empty after read", rx_full, 0);
    pulse_clr();
    check("R11", "overrun cleared", overrun, 0);
    cfg_slave = 0;
    eng_rx(8'h77);
    eng_rx(8'h88);
    check("R6", "master still stretches", xfer_cmpl, 1);
    check("R6", "master no overrun", overrun, 0);
    cpu_read(); cpu_read();
    check("R6", "drained", rx_full, 0);
  endtask

  task automatic t_tx_underrun();
    cfg_rx = 0; cfg_slave = 1; cfg_no_stretch = 1;
    check("R5", "empty before", tx_empty, 1);
    eng_load = 1; #1;
    check("R5", "fill byte", eng_tx_data, 8'hFF);
    step(); eng_load = 0;
    check("R5", "underrun set", underrun, 1);
    pulse_clr();
    check("R11", "underrun cleared", underrun, 0);
    cfg_slave = 0; cfg_no_stretch = 0;
  endtask

  task automatic t_dma_tx();
    cfg_rx = 0; cfg_dma_en = 1; #1;
    check("R7", "tx req on empty", dma_tx_req, 1);
    cfg_rx = 1; #1;
    check("R7", "no tx req in rx", dma_tx_req, 0);
    cfg_rx = 0;
    dma_tx_ack = 1; dma_wdata = 8'h5A; step(); dma_tx_ack = 0;
    check("R7", "req dropped", dma_tx_req, 0);
    check("R7", "buffer filled", tx_empty, 0);
    check("R7", "dma byte", eng_tx_data, 8'h5A);
    eng_load = 1; step(); eng_load = 0;
    check("R7", "req again", dma_tx_req, 1);
    cfg_dma_en = 0; #1;
    check("R7", "req off when disabled", dma_tx_req, 0);
  endtask

  task automatic t_dma_rx();
    cfg_rx = 1; cfg_dma_en = 1;
    eng_rx(8'h9C);
    check("R8", "rx req", dma_rx_req, 1);
    check("R8", "rx byte", rd_data, 8'h9C);
    dma_rx_ack = 1; step(); dma_rx_ack = 0;
    check("R8", "rx drained", rx_full, 0);
    check("R8", "rx req dropped", dma_rx_req, 0);
    cfg_dma_en = 0;
  endtask

  task automatic t_ack();
    cfg_rx = 1; cfg_slave = 0; cfg_ack_en = 1; cfg_last_xfer = 0; #1;
    check("R10", "plain ack", eng_ack, 1);
    cfg_ack_en = 0; #1;
    check("R9", "nack when disabled", eng_ack, 0);
    cfg_ack_en = 1; cfg_last_xfer = 1; #1;
    check("R10", "ack before eot", eng_ack, 1);
    dma_eot = 1; step(); dma_eot = 0;
    check("R11", "done set", dma_done, 1);
    check("R10", "nack after eot", eng_ack, 0);
    step(); step();
    check("R11", "done sticky", dma_done, 1);
    cfg_slave = 1; #1;
    check("R10", "slave keeps ack", eng_ack, 1);
    cfg_slave = 0; cfg_rx = 0; #1;
    check("R10", "tx keeps ack", eng_ack, 1);
    cfg_rx = 1;
    pulse_clr();
    check("R11", "done cleared", dma_done, 0);
    check("R10", "ack restored", eng_ack, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_rx = 0; cfg_slave = 0; cfg_no_stretch = 0; cfg_dma_en = 0;
    cfg_ack_en = 1; cfg_last_xfer = 0;
    wr_data = '0; dma_wdata = '0; eng_rx_data = '0;
    idle_inputs();
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_tx_stretch();
    t_rx_stretch();
    t_rx_overrun();
    t_tx_underrun();
    t_dma_tx();
    t_dma_rx();
    t_ack();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule